// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block is the counting core of a real-time clock. An external prescaled tick is divided down to 64 sub-second steps per second. Each completed second advances a packed-BCD calendar: seconds, minutes, hours, a weekday, day-of-month, month and a four-digit year. The year is held as a century byte above a two-digit year byte.

Software reaches the counters and two control registers through a small index-addressed register port. Reads are combinational and writes take effect on the clock edge. A carry flag is raised whenever a second completes, and on a minute carry caused by the half-minute adjust. Software clears the flag before a multi-register read, reads the fields, and reads the flag again. If the flag is set again, the counters moved during the read and software retries. The flag can also raise an interrupt.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the counters read sub-second 0, seconds 00, minutes 00, hours 00, weekday 0, day 01, month 01, year 0x2000. Both control registers read 0x00 and `carry_irq_o` is low.
- R2: When control-2 bit 0 (run) and bit 3 (enable) are both 1, the sub-second count advances once every TICKS_PER_STEP ticks. It wraps from 63 to 0, and that wrap advances the seconds by one in BCD.
- R3: A seconds wrap 59→00 advances the minutes. A minutes wrap 59→00 advances the hours. An hours wrap 23→00 advances the day and the weekday, and the weekday wraps 6→0.
- R4: The day wraps to 01 after the last day of its month (30 or 31, and 28 or 29 for February) and advances the month. A year is a leap year when it is divisible by 4 and either not divisible by 100 or divisible by 400. The month wraps 12→01 and advances the four-digit BCD year (index 7, century in bits 15:8), and 9999 wraps to 0000.
- R5: The counters hold while run or enable is 0. Writes to indices 1..7 are accepted only while run is 0 and are ignored while run is 1.
- R6: Writing control-2 with bit 1 (prescaler clear) set clears both the tick prescaler and the sub-second count. The bit always reads 0.
- R7: Writing control-2 with bit 2 (half-minute adjust) set forces the seconds to 00. If the seconds were 30 or more, the minutes also advance and carry onward as in R3. The bit always reads 0.
- R8: Control-1 bit 7 (carry flag) is set by every seconds advance and by an adjust that carries into the minutes. Writing 0 to that bit clears the flag, writing 1 leaves it unchanged, and a set in the same cycle wins over a clear.
- R9: `carry_irq_o` is high exactly while the carry flag and control-1 bit 4 (carry interrupt enable) are both 1.
- R10: The register map is as follows. Index 0 is the sub-second count (read-only), indices 1..6 are seconds, minutes, hours, weekday, day and month, index 7 is the year, index 14 is control-1 and index 15 is control-2. Unused indices and unused control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse from the external prescaled time base |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register index |
| wr_data_i | input | 16 | Write data (byte registers use bits 7:0) |
| rd_data_o | output | 16 | Combinational read data for `addr_i` |
| carry_irq_o | output | 1 | Carry interrupt |

## Verification
A wrong BCD increment or a wrong cascade limit shows up in the register reads on the second, minute, day or month boundary where it happens. The test therefore places the calendar one tick before such boundaries, including the leap and century cases, and reads every field immediately after the tick. A prescaler or sub-second error shifts the second boundary by whole steps, and this is seen one tick early or one tick late. A carry flag that is stuck or set at the wrong time is visible on the interrupt pin in the same cycle as the flag register.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

  typedef struct packed {
    logic [15:0] year;
    logic [7:0]  mon;
    logic [7:0]  day;
    logic [7:0]  wday;
    logic [7:0]  hour;
    logic [7:0]  min;
    logic [7:0]  sec;
  } rtc_time_t;

  // register indices: the software retry sequence depends on these positions
  localparam int IDX_SUB  = 0;
  localparam int IDX_SEC  = 1;
  localparam int IDX_MIN  = 2;
  localparam int IDX_HOUR = 3;
  localparam int IDX_WDAY = 4;
  localparam int IDX_DAY  = 5;
  localparam int IDX_MON  = 6;
  localparam int IDX_YEAR = 7;
  localparam int IDX_CTL1 = 14;
  localparam int IDX_CTL2 = 15;

  // control bit positions
  localparam int C1_FLAG  = 7;
  localparam int C1_IEN   = 4;
  localparam int C2_RUN   = 0;
  localparam int C2_CLR   = 1;
  localparam int C2_HALF  = 2;
  localparam int C2_ENA   = 3;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcd_val(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic logic is_leap(input logic [15:0] y);
    logic [7:0] yy, cc;
    yy = bcd_val(y[7:0]);
    cc = bcd_val(y[15:8]);
    if (yy != 8'd0) return (yy % 8'd4) == 8'd0;
    else            return (cc % 8'd4) == 8'd0;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int TICKS_PER_STEP = 2,
  parameter int SUB_STEPS      = 64,
  localparam int SUB_W         = $clog2(SUB_STEPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clear_i,
  output logic [SUB_W-1:0] subsec_o,
  output logic             sec_pulse_o
);
  localparam logic [SUB_W-1:0] SUB_MAX = SUB_W'(SUB_STEPS - 1);

  logic step;

  generate
    if (TICKS_PER_STEP == 1) begin : g_direct
      assign step = run_i & tick_i;
    end else begin : g_count
      localparam int PW = $clog2(TICKS_PER_STEP);
      localparam logic [PW-1:0] PMAX = PW'(TICKS_PER_STEP - 1);
      logic [PW-1:0] pcnt;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              pcnt <= '0;
        else if (clear_i)         pcnt <= '0;
        else if (run_i && tick_i) pcnt <= (pcnt == PMAX) ? '0 : pcnt + 1'b1;
      end
      assign step = run_i & tick_i & (pcnt == PMAX);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      subsec_o <= '0;
    else if (clear_i) subsec_o <= '0;
    else if (step)    subsec_o <= (subsec_o == SUB_MAX) ? '0 : subsec_o + 1'b1;
  end

  assign sec_pulse_o = step & (subsec_o == SUB_MAX);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_bcd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sec_pulse_i,
  input  logic        half_adj_i,
  input  logic        wr_i,
  input  logic [3:0]  wr_idx_i,
  input  logic [15:0] wr_data_i,
  output rtc_time_t   time_o,
  output logic        carry_o
);
  rtc_time_t cur, nxt;
  logic min_c, hour_c, day_c, mon_c, year_c;

  assign cur = time_o;

  always_comb begin
    nxt    = cur;
    min_c  = 1'b0;
    hour_c = 1'b0;
    day_c  = 1'b0;
    mon_c  = 1'b0;
    year_c = 1'b0;
    if (half_adj_i) begin
      nxt.sec = 8'h00;
      min_c   = (cur.sec >= 8'h30);
    end else if (sec_pulse_i) begin
      if (cur.sec >= 8'h59) begin nxt.sec = 8'h00; min_c = 1'b1; end
      else nxt.sec = bcd_inc(cur.sec);
    end else if (wr_i) begin
      case (int'(wr_idx_i))
        IDX_SEC:  nxt.sec  = wr_data_i[7:0];
        IDX_MIN:  nxt.min  = wr_data_i[7:0];
        IDX_HOUR: nxt.hour = wr_data_i[7:0];
        IDX_WDAY: nxt.wday = wr_data_i[7:0];
        IDX_DAY:  nxt.day  = wr_data_i[7:0];
        IDX_MON:  nxt.mon  = wr_data_i[7:0];
        IDX_YEAR: nxt.year = wr_data_i;
        default:  ;
      endcase
    end
    if (min_c) begin
      if (cur.min >= 8'h59) begin nxt.min = 8'h00; hour_c = 1'b1; end
      else nxt.min = bcd_inc(cur.min);
    end
    if (hour_c) begin
      if (cur.hour >= 8'h23) begin nxt.hour = 8'h00; day_c = 1'b1; end
      else nxt.hour = bcd_inc(cur.hour);
    end
    if (day_c) begin
      nxt.wday = (cur.wday >= 8'h06) ? 8'h00 : bcd_inc(cur.wday);
      if (cur.day >= month_len(cur.mon, is_leap(cur.year))) begin
        nxt.day = 8'h01;
        mon_c   = 1'b1;
      end else nxt.day = bcd_inc(cur.day);
    end
    if (mon_c) begin
      if (cur.mon >= 8'h12) begin nxt.mon = 8'h01; year_c = 1'b1; end
      else nxt.mon = bcd_inc(cur.mon);
    end
    if (year_c) begin
      if (cur.year[7:0] >= 8'h99) begin
        nxt.year[7:0]  = 8'h00;
        nxt.year[15:8] = (cur.year[15:8] >= 8'h99) ? 8'h00 : bcd_inc(cur.year[15:8]);
      end else nxt.year[7:0] = bcd_inc(cur.year[7:0]);
    end
  end

  assign carry_o = sec_pulse_i | min_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_o <= '{year: 16'h2000, mon: 8'h01, day: 8'h01, wday: 8'h00,
                  hour: 8'h00, min: 8'h00, sec: 8'h00};
    end else begin
      time_o <= nxt;
    end
  end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_bcd_pkg::*;
#(
  parameter int TICKS_PER_STEP = 2,
  parameter int SUB_STEPS      = 64,
  parameter int ADDR_W         = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wr_data_i,
  output logic [15:0]       rd_data_o,
  output logic              carry_irq_o
);
  localparam int SUB_W = $clog2(SUB_STEPS);

  logic             flag_q, ien_q, run_q, ena_q;
  logic             ctl1_wr, ctl2_wr, cnt_wr, run;
  logic             presc_clr, adj_evt, sec_pulse, carry_evt;
  logic [SUB_W-1:0] subsec;
  logic [7:0]       subsec8, sec_w;
  rtc_time_t        time_q;

  assign ctl1_wr   = wr_en_i && (addr_i == ADDR_W'(IDX_CTL1));
  assign ctl2_wr   = wr_en_i && (addr_i == ADDR_W'(IDX_CTL2));
  assign cnt_wr    = wr_en_i && !run_q && (addr_i >= ADDR_W'(IDX_SEC)) &&
                     (addr_i <= ADDR_W'(IDX_YEAR));
  assign run       = run_q & ena_q;
  assign presc_clr = ctl2_wr & wr_data_i[C2_CLR];
  assign adj_evt   = ctl2_wr & wr_data_i[C2_HALF];

  rtc_prescale #(.TICKS_PER_STEP(TICKS_PER_STEP), .SUB_STEPS(SUB_STEPS)) i_prescale (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (run),
    .clear_i    (presc_clr),
    .subsec_o   (subsec),
    .sec_pulse_o(sec_pulse)
  );

  rtc_calendar i_calendar (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sec_pulse_i(sec_pulse),
    .half_adj_i (adj_evt),
    .wr_i       (cnt_wr),
    .wr_idx_i   (addr_i[3:0]),
    .wr_data_i  (wr_data_i),
    .time_o     (time_q),
    .carry_o    (carry_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
      run_q  <= 1'b0;
      ena_q  <= 1'b0;
    end else begin
      if (carry_evt)                         flag_q <= 1'b1;
      else if (ctl1_wr && !wr_data_i[C1_FLAG]) flag_q <= 1'b0;
      if (ctl1_wr) ien_q <= wr_data_i[C1_IEN];
      if (ctl2_wr) begin
        run_q <= wr_data_i[C2_RUN];
        ena_q <= wr_data_i[C2_ENA];
      end
    end
  end

  assign carry_irq_o = flag_q & ien_q;
  assign subsec8     = {{(8-SUB_W){1'b0}}, subsec};
  assign sec_w       = time_q.sec;

  always_comb begin
    rd_data_o = 16'h0000;
    if (addr_i <= ADDR_W'(IDX_CTL2)) begin
      case (int'(addr_i[3:0]))
        IDX_SUB:  rd_data_o = {8'h00, subsec8};
        IDX_SEC:  rd_data_o = {8'h00, sec_w};
        IDX_MIN:  rd_data_o = {8'h00, time_q.min};
        IDX_HOUR: rd_data_o = {8'h00, time_q.hour};
        IDX_WDAY: rd_data_o = {8'h00, time_q.wday};
        IDX_DAY:  rd_data_o = {8'h00, time_q.day};
        IDX_MON:  rd_data_o = {8'h00, time_q.mon};
        IDX_YEAR: rd_data_o = time_q.year;
        IDX_CTL1: rd_data_o = {8'h00, flag_q, 2'b00, ien_q, 4'h0};
        IDX_CTL2: rd_data_o = {12'h000, ena_q, 2'b00, run_q};
        default:  rd_data_o = 16'h0000;
      endcase
    end
  end
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       carry_evt,
  input logic       sec_pulse,
  input logic       adj_evt,
  input logic       flag_q,
  input logic       carry_irq_o,
  input logic [7:0] subsec8,
  input logic [7:0] sec_w,
  input logic       cnt_wr,
  input logic       run,
  input logic       ctl1_wr,
  input logic       clr_bit
);
  a_r8_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_evt |=> flag_q);

  a_r8_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl1_wr && !clr_bit && !carry_evt) |=> !flag_q);

  a_r9_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_irq_o |-> flag_q);

  a_r2_subsec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse |=> (subsec8 == 8'h00));

  a_r5_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cnt_wr && !adj_evt) |=> $stable(sec_w));

  a_r7_adj_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_evt |=> (sec_w == 8'h00));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .carry_evt  (carry_evt),
  .sec_pulse  (sec_pulse),
  .adj_evt    (adj_evt),
  .flag_q     (flag_q),
  .carry_irq_o(carry_irq_o),
  .subsec8    (subsec8),
  .sec_w      (sec_w),
  .cnt_wr     (cnt_wr),
  .run        (run),
  .ctl1_wr    (ctl1_wr),
  .clr_bit    (wr_data_i[7])
);

// File: tb/test_rtc_bcd_core.sv
module test_rtc_bcd_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  rtc_bcd_core i_rtc_bcd_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .carry_irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 4'(idx); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [15:0] d);
    @(negedge clk); addr = 4'(idx); #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  function automatic logic [7:0] to_bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    bit lp;
    lp = ((y % 400) == 0) || (((y % 4) == 0) && ((y % 100) != 0));
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic set_time(input int s, input int mi, input int h, input int wd,
                          input int d, input int mo, input int y);
    wr(15, 16'h0008);
    wr(1, {8'h00, to_bcd(s)});  wr(2, {8'h00, to_bcd(mi)});
    wr(3, {8'h00, to_bcd(h)});  wr(4, {8'h00, to_bcd(wd)});
    wr(5, {8'h00, to_bcd(d)});  wr(6, {8'h00, to_bcd(mo)});
    wr(7, {to_bcd(y / 100), to_bcd(y % 100)});
    wr(14, 16'h0000);
    wr(15, 16'h000B);
  endtask

  task automatic check_time(input string req, input int s, input int mi, input int h,
                            input int wd, input int d, input int mo, input int y);
    logic [15:0] v;
    rd(1, v); chk({req, " sec"},  v, {8'h00, to_bcd(s)});
    rd(2, v); chk({req, " min"},  v, {8'h00, to_bcd(mi)});
    rd(3, v); chk({req, " hour"}, v, {8'h00, to_bcd(h)});
    rd(4, v); chk({req, " wday"}, v, {8'h00, to_bcd(wd)});
    rd(5, v); chk({req, " day"},  v, {8'h00, to_bcd(d)});
    rd(6, v); chk({req, " mon"},  v, {8'h00, to_bcd(mo)});
    rd(7, v); chk({req, " year"}, v, {to_bcd(y / 100), to_bcd(y % 100)});
  endtask

  // one full second from a fresh start, compared with the bench's own calendar
  task automatic one_second(input string req, input int s, input int mi, input int h,
                            input int wd, input int d, input int mo, input int y);
    logic [15:0] v;
    set_time(s, mi, h, wd, d, mo, y);
    ticks(127);
    rd(0, v); chk("R2 subsec before wrap", v, 16'd63);
    rd(1, v); chk("R2 sec held before wrap", v, {8'h00, to_bcd(s)});
    ticks(1);
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0; wd = (wd + 1) % 7; d++;
          if (d > dim(mo, y)) begin
            d = 1; mo++;
            if (mo == 13) begin mo = 1; y = (y + 1) % 10000; end
          end
        end
      end
    end
    check_time(req, s, mi, h, wd, d, mo, y);
    rd(14, v); chk("R8 flag after second", v & 16'h0080, 16'h0080);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    int s, mi, h, mo, y, d;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, v);  chk("R1 subsec", v, 16'h0000);
    check_time("R1", 0, 0, 0, 0, 1, 1, 2000);
    rd(14, v); chk("R1 ctl1", v, 16'h0000);
    rd(15, v); chk("R1 ctl2", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R10 unused index and read-only sub-second
    rd(9, v);  chk("R10 unused index", v, 16'h0000);
    wr(0, 16'h002A);
    rd(0, v);  chk("R10 subsec read-only", v, 16'h0000);

    // R3 R4 directed boundaries
    one_second("R3 hour and weekday wrap", 59, 59, 23, 6, 31, 12, 1999);
    one_second("R4 leap century feb", 59, 59, 23, 1, 28, 2, 2000);
    one_second("R4 non-leap century feb", 59, 59, 23, 2, 28, 2, 1900);
    one_second("R4 leap year feb", 59, 59, 23, 3, 28, 2, 2024);
    one_second("R4 feb 29 end", 59, 59, 23, 4, 29, 2, 2024);
    one_second("R4 thirty-day month", 59, 59, 23, 5, 30, 4, 2023);
    one_second("R4 year 9999 wrap", 59, 59, 23, 0, 31, 12, 9999);
    one_second("R3 minute carry only", 59, 14, 8, 2, 10, 7, 2031);

    // R2 R3 R4 constrained random, biased toward rollover points
    for (int k = 0; k < 24; k++) begin
      s  = ($urandom % 2) ? 59 : int'($urandom % 60);
      mi = ($urandom % 2) ? 59 : int'($urandom % 60);
      h  = ($urandom % 2) ? 23 : int'($urandom % 24);
      mo = 1 + int'($urandom % 12);
      case ($urandom % 4)
        0: y = 2000;
        1: y = 2100;
        2: y = 1996 + int'($urandom % 8);
        default: y = int'($urandom % 10000);
      endcase
      d = ($urandom % 2) ? dim(mo, y) : 1 + int'($urandom % dim(mo, y));
      one_second("R4 random", s, mi, h, int'($urandom % 7), d, mo, y);
    end

    // R5 writes ignored while running, hold when enable is low
    set_time(30, 20, 10, 3, 15, 6, 2022);
    wr(1, 16'h0045);
    rd(1, v);  chk("R5 write ignored while running", v, 16'h0030);
    wr(15, 16'h0001);
    ticks(200);
    rd(1, v);  chk("R5 hold with enable low", v, 16'h0030);
    rd(0, v);  chk("R5 subsec hold with enable low", v, 16'h0000);
    wr(1, 16'h0045);
    rd(1, v);  chk("R5 write ignored run set enable low", v, 16'h0030);
    wr(15, 16'h0008);
    wr(1, 16'h0045);
    rd(1, v);  chk("R5 write accepted while stopped", v, 16'h0045);
    ticks(200);
    rd(0, v);  chk("R5 stopped no sub-second count", v, 16'h0000);

    // R6 prescaler clear
    wr(15, 16'h000B);
    ticks(51);
    rd(0, v);  chk("R6 subsec count before clear", v, 16'd25);
    wr(15, 16'h000B);
    rd(0, v);  chk("R6 subsec cleared", v, 16'h0000);
    rd(15, v); chk("R6 clear bit reads zero", v, 16'h0009);
    ticks(1);
    rd(0, v);  chk("R6 prescaler cleared first tick", v, 16'h0000);
    ticks(1);
    rd(0, v);  chk("R6 prescaler cleared second tick", v, 16'h0001);

    // R7 half-minute adjust
    wr(15, 16'h0008);
    wr(14, 16'h0000);
    wr(1, 16'h0029); wr(2, 16'h0010);
    wr(15, 16'h000C);
    rd(1, v);  chk("R7 low half to zero", v, 16'h0000);
    rd(2, v);  chk("R7 low half keeps minute", v, 16'h0010);
    rd(15, v); chk("R7 adjust bit reads zero", v, 16'h0008);
    rd(14, v); chk("R8 no flag without carry", v, 16'h0000);
    wr(1, 16'h0045); wr(2, 16'h0059); wr(3, 16'h0005);
    wr(15, 16'h000C);
    rd(1, v);  chk("R7 high half to zero", v, 16'h0000);
    rd(2, v);  chk("R7 minute carry", v, 16'h0000);
    rd(3, v);  chk("R7 hour cascade", v, 16'h0006);
    rd(14, v); chk("R8 flag on adjust carry", v, 16'h0080);

    // R8 R9 flag write rules and interrupt
    chk("R9 irq low without enable", {15'd0, irq}, 16'h0000);
    wr(14, 16'h0090);
    rd(14, v); chk("R8 write one keeps flag", v, 16'h0090);
    chk("R9 irq with flag and enable", {15'd0, irq}, 16'h0001);
    wr(14, 16'h0010);
    rd(14, v); chk("R8 write zero clears flag", v, 16'h0010);
    chk("R9 irq low after clear", {15'd0, irq}, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule